// File: doc/BRIEF.md
# Banked Window Address Translator

This block turns a 16-bit physical address from a processor into a 24-bit extended address. A programmable window is defined by a start and an end address. A physical address that falls inside the window is relocated. Its offset from the window start is added to a page number, which is first shifted left by a programmable amount, and to a programmable virtual base. An address outside the window leaves the block unchanged, zero-extended to 24 bits.

An 8-bit initialisation value places two fixed blocks in the 16-bit map, each on a 4 KiB boundary:
- Its low nibble gives the base of the register block.
- Its high nibble gives the base of the internal RAM block.

The block reports which region the current address hits. The register block takes precedence over the RAM block, and the RAM block takes precedence over everything else, which is external memory.

Configuration goes through a plain write port: write enable, register select and write data. The translation path is combinational and carries a valid/ready pair straight through:
- The request may advance only when the consumer is ready.
- While the consumer stalls, the requester must hold its address steady.
- The block holds nothing itself.

Top module: `bank_xlate_top`

## Requirements
- R1: An address is inside the window exactly when window start <= address < window end. The start address itself is inside and the end address itself is outside. `in_window` reports this.
- R2: For an address inside the window, `virt_addr` = (address - start) + (page << shift) + virtual base, taken modulo 2^24.
- R3: For an address outside the window, `virt_addr` equals the address zero-extended to 24 bits.
- R4: When start >= end, the window is empty and no address matches, including the start value itself.
- R5: `io_base` equals init[3:0] placed in bits 15:12, with bits 11:0 zero.
- R6: `ram_base` equals init[7:4] placed in bits 15:12, with bits 11:0 zero.
- R7: `region` encodes the hit region:
  - 2 = register block, covering [io_base, io_base+64).
  - 1 = RAM block, covering [ram_base, ram_base+256).
  - 0 = external.
  - Where the two blocks overlap, the register block wins.
- R8: On a clock edge with `cfg_we` high, `cfg_sel` chooses the register to load from the low bits of `cfg_wdata`:
  - 0 loads start (16 bits).
  - 1 loads end (16 bits).
  - 2 loads shift (4 bits, 0..15).
  - 3 loads virtual base (24 bits).
  - 4 loads page (8 bits).
  - 5 loads init (8 bits).
  - Selects 6 and 7 change nothing.
  - The new value affects the outputs from the cycle after the write.
- R9: Reset sets every configuration register to zero. After reset the window is therefore empty and both block bases are 0x0000.
- R10: `rsp_valid` follows `req_valid` and `req_ready` follows `rsp_ready` in the same cycle. A stalled request (valid high, ready low) keeps its outputs valid and unchanged while the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| req_valid | input | 1 | Physical address valid |
| req_ready | output | 1 | Translator can accept the address |
| req_addr | input | 16 | Physical address |
| rsp_valid | output | 1 | Translated result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| virt_addr | output | 24 | Extended address |
| in_window | output | 1 | Address lies inside the bank window |
| region | output | 2 | Region code (0 external, 1 RAM, 2 register block) |
| io_base | output | 16 | Register block base address |
| ram_base | output | 16 | RAM block base address |

## Verification
The hardest cases to reach are at the arithmetic edges of the window.

One is the 24-bit sum wrapping past its top. The stimulus reaches it by loading a virtual base just below 2^24 and translating an offset that carries it over. A second is the largest shift with a full page, which fills bit 22.

The other hard cases involve ordering. Both fixed blocks are placed on the same 4 KiB boundary so that the register block must win over the RAM block. The window is also loaded with start above end, and with start equal to end, to show that no address matches.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  typedef enum logic [1:0] {
    RGN_EXT = 2'd0,
    RGN_RAM = 2'd1,
    RGN_IO  = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    SEL_START = 3'd0,
    SEL_END   = 3'd1,
    SEL_SHIFT = 3'd2,
    SEL_VBASE = 3'd3,
    SEL_PAGE  = 3'd4,
    SEL_INIT  = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bank_xlate_pkg::*;
#(
  parameter int PA_W   = 16,
  parameter int VA_W   = 24,
  parameter int SH_W   = 4,
  parameter int PAGE_W = 8,
  parameter int INIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [VA_W-1:0]   wdata,
  output logic [PA_W-1:0]   win_start,
  output logic [PA_W-1:0]   win_end,
  output logic [SH_W-1:0]   shift,
  output logic [VA_W-1:0]   vbase,
  output logic [PAGE_W-1:0] page,
  output logic [INIT_W-1:0] init
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_start <= '0;
      win_end   <= '0;
      shift     <= '0;
      vbase     <= '0;
      page      <= '0;
      init      <= '0;
    end else if (we) begin
      case (sel)
        SEL_START: win_start <= wdata[PA_W-1:0];
        SEL_END:   win_end   <= wdata[PA_W-1:0];
        SEL_SHIFT: shift     <= wdata[SH_W-1:0];
        SEL_VBASE: vbase     <= wdata;
        SEL_PAGE:  page      <= wdata[PAGE_W-1:0];
        SEL_INIT:  init      <= wdata[INIT_W-1:0];
        default: ;
      endcase
    end
  end

  // R8
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_PAGE) |=> page == $past(wdata[PAGE_W-1:0]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || sel > SEL_INIT) |=> ($stable(win_start) && $stable(win_end) && $stable(vbase)));
endmodule

// File: rtl/win_xlate.sv
module win_xlate #(
  parameter int PA_W   = 16,
  parameter int VA_W   = 24,
  parameter int SH_W   = 4,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   addr,
  input  logic [PA_W-1:0]   win_start,
  input  logic [PA_W-1:0]   win_end,
  input  logic [SH_W-1:0]   shift,
  input  logic [VA_W-1:0]   vbase,
  input  logic [PAGE_W-1:0] page,
  output logic [VA_W-1:0]   virt,
  output logic              hit
);
  logic [PA_W-1:0] offset;
  logic [VA_W-1:0] paged;

  always_comb begin
    hit    = (addr >= win_start) && (addr < win_end);
    offset = addr - win_start;
    paged  = VA_W'(page) << shift;
    virt   = hit ? (VA_W'(offset) + paged + vbase) : VA_W'(addr);
  end

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> virt == VA_W'(addr));

  // R4
  empty_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start >= win_end) |-> !hit);

  // R1
  lo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start < win_end && addr == win_start) |-> (hit && virt == paged + vbase));
endmodule

// File: rtl/blk_base_decode.sv
module blk_base_decode
  import bank_xlate_pkg::*;
#(
  parameter int PA_W     = 16,
  parameter int INIT_W   = 8,
  parameter int IO_SPAN  = 64,
  parameter int RAM_SPAN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   addr,
  input  logic [INIT_W-1:0] init,
  output logic [PA_W-1:0]   io_base,
  output logic [PA_W-1:0]   ram_base,
  output region_e           region
);
  localparam int NIB = INIT_W / 2;
  localparam int LOW = PA_W - NIB;
  localparam int CW  = PA_W + 1;

  logic io_hit, ram_hit;

  always_comb begin
    io_base  = {init[NIB-1:0], {LOW{1'b0}}};
    ram_base = {init[INIT_W-1:NIB], {LOW{1'b0}}};
    io_hit   = (addr >= io_base) &&
               (CW'(addr) < CW'(io_base) + CW'(IO_SPAN));
    ram_hit  = (addr >= ram_base) &&
               (CW'(addr) < CW'(ram_base) + CW'(RAM_SPAN));
    if (io_hit)       region = RGN_IO;
    else if (ram_hit) region = RGN_RAM;
    else              region = RGN_EXT;
  end

  // R5
  io_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region == RGN_IO |-> addr[PA_W-1:LOW] == init[NIB-1:0]);

  // R6
  ram_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region == RGN_RAM |-> addr[PA_W-1:LOW] == init[INIT_W-1:NIB]);

  // R7
  io_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_base == ram_base && addr == io_base) |-> region == RGN_IO);
endmodule

// File: rtl/bank_xlate_top.sv
module bank_xlate_top
  import bank_xlate_pkg::*;
#(
  parameter int PA_W     = 16,
  parameter int VA_W     = 24,
  parameter int SH_W     = 4,
  parameter int PAGE_W   = 8,
  parameter int INIT_W   = 8,
  parameter int IO_SPAN  = 64,
  parameter int RAM_SPAN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [VA_W-1:0] cfg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_addr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] virt_addr,
  output logic            in_window,
  output logic [1:0]      region,
  output logic [PA_W-1:0] io_base,
  output logic [PA_W-1:0] ram_base
);
  logic [PA_W-1:0]   win_start, win_end;
  logic [SH_W-1:0]   shift;
  logic [VA_W-1:0]   vbase;
  logic [PAGE_W-1:0] page;
  logic [INIT_W-1:0] init;
  region_e           rgn;

  bank_cfg_regs #(.PA_W(PA_W), .VA_W(VA_W), .SH_W(SH_W), .PAGE_W(PAGE_W), .INIT_W(INIT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .win_start(win_start), .win_end(win_end), .shift(shift), .vbase(vbase),
    .page(page), .init(init)
  );

  win_xlate #(.PA_W(PA_W), .VA_W(VA_W), .SH_W(SH_W), .PAGE_W(PAGE_W)) u_xlate (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .win_start(win_start), .win_end(win_end),
    .shift(shift), .vbase(vbase), .page(page), .virt(virt_addr), .hit(in_window)
  );

  blk_base_decode #(.PA_W(PA_W), .INIT_W(INIT_W), .IO_SPAN(IO_SPAN), .RAM_SPAN(RAM_SPAN)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .init(init),
    .io_base(io_base), .ram_base(ram_base), .region(rgn)
  );

  assign region    = rgn;
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;

  // R10
  stall_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_ready) |-> (rsp_valid && !req_ready));

  // R10
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && !rsp_ready) && $stable(req_addr) && !$past(cfg_we)) |-> $stable(virt_addr));
endmodule

// File: tb/test_bank_xlate_top.sv
module test_bank_xlate_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [23:0] cfg_wdata = 0;
  logic        req_valid = 0, rsp_ready = 1;
  logic [15:0] req_addr = 0;
  logic        req_ready, rsp_valid, in_window;
  logic [23:0] virt_addr;
  logic [1:0]  region;
  logic [15:0] io_base, ram_base;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_start = 0, m_end = 0;
  logic [3:0]  m_shift = 0;
  logic [23:0] m_vbase = 0;
  logic [7:0]  m_page = 0;

  always #2.5 clk = ~clk;

  bank_xlate_top i_bank_xlate_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .virt_addr(virt_addr),
    .in_window(in_window), .region(region), .io_base(io_base), .ram_base(ram_base)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [23:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      3'd0: m_start = d[15:0];
      3'd1: m_end   = d[15:0];
      3'd2: m_shift = d[3:0];
      3'd3: m_vbase = d;
      3'd4: m_page  = d[7:0];
      default: ;
    endcase
  endtask

  function automatic logic [23:0] model(logic [15:0] a);
    if (a >= m_start && a < m_end)
      return {8'h0, a - m_start} + ({16'h0, m_page} << m_shift) + m_vbase;
    return {8'h0, a};
  endfunction

  task automatic probe(string req, logic [15:0] a, logic exp_hit);
    req_addr = a; req_valid = 1;
    #1;
    check(req, {31'h0, in_window}, {31'h0, exp_hit});
    check(req, {8'h0, virt_addr}, {8'h0, model(a)});
  endtask

  task automatic t_reset;
    probe("R9", 16'h1234, 0);
    check("R9", {16'h0, io_base}, 32'h0);
    check("R9", {16'h0, ram_base}, 32'h0);
    probe("R9", 16'h0000, 0);
    check("R7", {30'h0, region}, 32'd2);
  endtask

  task automatic t_window;
    wr(3'd0, 24'h008000); wr(3'd1, 24'h00C000); wr(3'd2, 24'h00000E);
    wr(3'd3, 24'h100000); wr(3'd4, 24'h000003);
    probe("R1", 16'h8000, 1);
    check("R2", {8'h0, virt_addr}, 32'h10C000);
    probe("R2", 16'hBFFF, 1);
    check("R2", {8'h0, virt_addr}, 32'h10FFFF);
    probe("R1", 16'hC000, 0);
    check("R3", {8'h0, virt_addr}, 32'h00C000);
    probe("R3", 16'h7FFF, 0);
  endtask

  task automatic t_arith;
    wr(3'd3, 24'hFFFF00); wr(3'd2, 24'h0); wr(3'd4, 24'h0);
    probe("R2", 16'h8100, 1);
    check("R2", {8'h0, virt_addr}, 32'h000000);
    wr(3'd3, 24'h0); wr(3'd2, 24'h00000F); wr(3'd4, 24'h0000FF);
    probe("R2", 16'h8001, 1);
    check("R2", {8'h0, virt_addr}, 32'h7F8001);
  endtask

  task automatic t_empty;
    wr(3'd0, 24'h009000); wr(3'd1, 24'h009000);
    probe("R4", 16'h9000, 0);
    wr(3'd0, 24'h00A000); wr(3'd1, 24'h002000);
    probe("R4", 16'hA000, 0);
    probe("R4", 16'h1000, 0);
  endtask

  task automatic t_bases;
    wr(3'd5, 24'h00005A);
    check("R5", {16'h0, io_base}, 32'hA000);
    check("R6", {16'h0, ram_base}, 32'h5000);
    req_addr = 16'hA03F; #1; check("R7", {30'h0, region}, 32'd2);
    req_addr = 16'hA040; #1; check("R7", {30'h0, region}, 32'd0);
    req_addr = 16'h50FF; #1; check("R7", {30'h0, region}, 32'd1);
    req_addr = 16'h5100; #1; check("R7", {30'h0, region}, 32'd0);
    wr(3'd5, 24'h000033);
    req_addr = 16'h3010; #1; check("R7", {30'h0, region}, 32'd2);
    req_addr = 16'h3080; #1; check("R7", {30'h0, region}, 32'd1);
  endtask

  task automatic t_ignore;
    wr(3'd0, 24'h004000); wr(3'd1, 24'h005000); wr(3'd3, 24'h020000);
    wr(3'd4, 24'h0); wr(3'd2, 24'h0);
    wr(3'd6, 24'hFFFFFF); wr(3'd7, 24'h123456);
    probe("R8", 16'h4010, 1);
    check("R8", {8'h0, virt_addr}, 32'h020010);
    check("R8", {16'h0, io_base}, 32'h3000);
    wr(3'd0, 24'hAB4800);
    probe("R8", 16'h4010, 0);
  endtask

  task automatic t_handshake;
    req_addr = 16'h4800; req_valid = 1; rsp_ready = 0; #1;
    check("R10", {31'h0, rsp_valid}, 32'd1);
    check("R10", {31'h0, req_ready}, 32'd0);
    @(negedge clk); #1;
    check("R10", {8'h0, virt_addr}, 32'h020000);
    rsp_ready = 1; req_valid = 0; #1;
    check("R10", {31'h0, req_ready}, 32'd1);
    check("R10", {31'h0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_window;
    t_arith;
    t_empty;
    t_bases;
    t_ignore;
    t_handshake;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule